// File: doc/BRIEF.md
# Serial Priority Shutdown Decoder

This block turns a single fast-shutdown input into one-cycle turn-off requests for a group of power ports (eight by default). The raw input is synchronised and then deglitched, so only pulses that last longer than a set number of clock cycles are seen. The filtered input is then read in one of two ways, chosen by a mode input.

In level mode, a rising edge of the filtered input sends a turn-off pulse to every port that software has marked as low priority. In serial mode, the input carries short frames. Each frame is a start bit followed by a 3-bit code, sent most significant bit first. Every port whose 3-bit priority setting is greater than or equal to that code is turned off. A setting of 000 is the most important port. After each frame the decoder stays deaf until the line has been quiet again. When serial mode is first selected, it also waits for a longer quiet period, so that it starts in step with the bit stream.

The downstream port controllers use the output vector as their fast turn-off strobe.

Top module: `shutdown_prio_decoder`

## Requirements
- R1: A change of the raw input reaches the decoder only after the synchronised value has differed from the filtered value for DEGLITCH_CYC consecutive clock cycles. Shorter pulses have no effect on the output.
- R2: With serial_mode_i = 0, each rising edge of the filtered input produces a one-cycle pulse on port_off_o equal to low_prio_mask_i. Bit i = 1 marks port i as low priority, and bit i = 0 keeps port i on.
- R3: With serial_mode_i = 0, an input that stays high after its rising edge produces no further pulse.
- R4: With serial_mode_i = 1, a frame starts with a high start bit, followed by three data bits sent MSB first (high = 1). Each bit lasts BIT_CYC cycles, and each bit is sampled at its middle (BIT_CYC/2 cycles into the bit).
- R5: At the end of a frame carrying code C, bit i of port_off_o pulses exactly when C <= P_i. P_i is the priority of port i, held in prio_flat_i[3*i+2 : 3*i]. The value 000 is the highest priority.
- R6: A code greater than every port's priority produces no pulse.
- R7: After serial_mode_i becomes 1, frames are ignored until the filtered input has been low for ARM_CYC consecutive cycles.
- R8: After a frame or an aborted start, the input is ignored until it has been low for GAP_CYC consecutive cycles. A second frame sent without that gap produces no pulse.
- R9: A start bit that is low again at its middle sample point is discarded, and no pulse is produced.
- R10: port_off_o is zero during reset, and each pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_raw_i | input | 1 | Raw fast-shutdown input, asynchronous |
| serial_mode_i | input | 1 | 0 = level mode, 1 = serial code mode |
| low_prio_mask_i | input | NUM_PORTS | Level mode: 1 = port is low priority |
| prio_flat_i | input | NUM_PORTS*3 | Per-port 3-bit priority, port i at bits 3*i+2:3*i |
| port_off_o | output | NUM_PORTS | One-cycle turn-off request per port |

## Verification
Several properties are checked on every cycle:
- The filtered signal only ever moves toward the synchronised input.
- Level-mode pulses never reach a port outside the low-priority mask.
- Pulses are one cycle wide.
- The comparison results are monotonic across ports: if a port is turned off, every port with a numerically larger priority is turned off too.
- The receiver leaves its arming state only while serial mode is held, and it goes idle only after a low input.

Other behaviours depend on timed input waveforms, and only the bench scenarios can show them. These are:
- rejection of short glitches;
- the MSB-first code at mid-bit sampling;
- frames ignored during arming and without a gap;
- aborted start bits;
- codes that turn off no port.

// File: rtl/shutdown_dec_pkg.sv
package shutdown_dec_pkg;

  localparam int PRIO_W = 3;

  typedef enum logic [1:0] {
    RX_ARM   = 2'd0,
    RX_IDLE  = 2'd1,
    RX_FRAME = 2'd2,
    RX_GAP   = 2'd3
  } rx_state_e;

  // A port is switched off when the received code does not exceed its priority value.
  function automatic logic prio_hit(logic [PRIO_W-1:0] code, logic [PRIO_W-1:0] prio);
    return (code <= prio);
  endfunction

endpackage

// File: rtl/shutdown_deglitch.sv
module shutdown_deglitch #(
  parameter int SYNC_STAGES  = 2,
  parameter int DEGLITCH_CYC = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(DEGLITCH_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   synced_w;
  logic [CW-1:0]          cnt_q;
  logic                   filt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end
  assign synced_w = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else if (synced_w == filt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(DEGLITCH_CYC - 1)) begin
      filt_q <= synced_w;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
  assign filt_o = filt_q;

  // R1: the filtered level only moves toward the synchronised input
  assert_filter_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> ($past(synced_w) == filt_q));

endmodule

// File: rtl/shutdown_serial_rx.sv
module shutdown_serial_rx
  import shutdown_dec_pkg::*;
#(
  parameter int BIT_CYC = 2500,
  parameter int GAP_CYC = 2000,
  parameter int ARM_CYC = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              serial_en_i,
  input  logic              din_i,
  output logic [PRIO_W-1:0] code_o,
  output logic              done_o
);
  localparam int MAXC = (ARM_CYC > GAP_CYC) ? ((ARM_CYC > BIT_CYC) ? ARM_CYC : BIT_CYC)
                                            : ((GAP_CYC > BIT_CYC) ? GAP_CYC : BIT_CYC);
  localparam int CW   = $clog2(MAXC + 1);
  localparam int HALF = BIT_CYC / 2;
  localparam int BW   = $clog2(PRIO_W + 1);

  rx_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [BW-1:0]     bidx_q;
  logic [PRIO_W-1:0] shreg_q;
  logic              sample_pt_w;
  logic              last_bit_w;
  logic              start_bad_w;
  logic [CW-1:0]     quiet_lim_w;

  assign sample_pt_w = (state_q == RX_FRAME) && (cnt_q == CW'(HALF));
  assign last_bit_w  = (bidx_q == BW'(PRIO_W));
  assign start_bad_w = sample_pt_w && (bidx_q == '0) && !din_i;
  assign quiet_lim_w = (state_q == RX_ARM) ? CW'(ARM_CYC - 1) : CW'(GAP_CYC - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_ARM;
      cnt_q   <= '0;
      bidx_q  <= '0;
      shreg_q <= '0;
    end else if (!serial_en_i) begin
      state_q <= RX_ARM;
      cnt_q   <= '0;
      bidx_q  <= '0;
    end else begin
      unique case (state_q)
        RX_ARM, RX_GAP: begin
          if (din_i) begin
            cnt_q <= '0;
          end else if (cnt_q == quiet_lim_w) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_IDLE: begin
          if (din_i) begin
            state_q <= RX_FRAME;
            cnt_q   <= CW'(1);
            bidx_q  <= '0;
          end
        end
        RX_FRAME: begin
          if (cnt_q == CW'(BIT_CYC - 1)) begin
            cnt_q  <= '0;
            bidx_q <= bidx_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
          if (sample_pt_w) begin
            if (start_bad_w || last_bit_w) begin
              state_q <= RX_GAP;
              cnt_q   <= '0;
            end
            if (bidx_q != '0) shreg_q <= {shreg_q[PRIO_W-2:0], din_i};
          end
        end
        default: state_q <= RX_ARM;
      endcase
    end
  end

  assign code_o = {shreg_q[PRIO_W-2:0], din_i};
  assign done_o = sample_pt_w && last_bit_w;

  // R7: the arming state is left only while serial mode is held
  assert_arm_needs_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != RX_ARM) |-> $past(serial_en_i));

  // R8: idle is entered only after a low input
  assert_idle_after_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_IDLE && $past(state_q) != RX_IDLE) |-> !$past(din_i));

  // R9: an aborted start never completes a frame
  assert_false_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_bad_w |=> (state_q == RX_GAP));

endmodule

// File: rtl/shutdown_prio_cmp.sv
module shutdown_prio_cmp
  import shutdown_dec_pkg::*;
#(
  parameter int NUM_PORTS = 8
) (
  input  logic                        valid_i,
  input  logic [PRIO_W-1:0]           code_i,
  input  logic [NUM_PORTS*PRIO_W-1:0] prio_flat_i,
  output logic [NUM_PORTS-1:0]        hit_o
);
  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    assign hit_o[g] = valid_i & prio_hit(code_i, prio_flat_i[g*PRIO_W +: PRIO_W]);
  end

  // R5: a port that is switched off implies all ports of equal or lower importance switch off too
  always_comb begin
    if (valid_i) begin
      for (int i = 0; i < NUM_PORTS; i++) begin
        for (int j = 0; j < NUM_PORTS; j++) begin
          if (hit_o[i] && (prio_flat_i[j*PRIO_W +: PRIO_W] >= prio_flat_i[i*PRIO_W +: PRIO_W]))
            assert_monotonic_R5: assert (hit_o[j]);
        end
      end
    end
  end

endmodule

// File: rtl/shutdown_prio_decoder.sv
module shutdown_prio_decoder
  import shutdown_dec_pkg::*;
#(
  parameter int NUM_PORTS    = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int DEGLITCH_CYC = 300,
  parameter int BIT_CYC      = 2500,
  parameter int GAP_CYC      = 2000,
  parameter int ARM_CYC      = 20000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        shdn_raw_i,
  input  logic                        serial_mode_i,
  input  logic [NUM_PORTS-1:0]        low_prio_mask_i,
  input  logic [NUM_PORTS*PRIO_W-1:0] prio_flat_i,
  output logic [NUM_PORTS-1:0]        port_off_o
);
  logic                 filt_w;
  logic                 filt_q;
  logic                 level_rise_w;
  logic                 frame_done_w;
  logic [PRIO_W-1:0]    frame_code_w;
  logic [NUM_PORTS-1:0] serial_hit_w;
  logic [NUM_PORTS-1:0] off_d;
  logic [NUM_PORTS-1:0] off_q;

  shutdown_deglitch #(
    .SYNC_STAGES (SYNC_STAGES),
    .DEGLITCH_CYC(DEGLITCH_CYC)
  ) u_deglitch (
    .clk   (clk),
    .rst_n (rst_n),
    .raw_i (shdn_raw_i),
    .filt_o(filt_w)
  );

  shutdown_serial_rx #(
    .BIT_CYC(BIT_CYC),
    .GAP_CYC(GAP_CYC),
    .ARM_CYC(ARM_CYC)
  ) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .serial_en_i(serial_mode_i),
    .din_i      (filt_w),
    .code_o     (frame_code_w),
    .done_o     (frame_done_w)
  );

  shutdown_prio_cmp #(
    .NUM_PORTS(NUM_PORTS)
  ) u_cmp (
    .valid_i    (frame_done_w),
    .code_i     (frame_code_w),
    .prio_flat_i(prio_flat_i),
    .hit_o      (serial_hit_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) filt_q <= 1'b0;
    else        filt_q <= filt_w;
  end

  assign level_rise_w = filt_w & ~filt_q & ~serial_mode_i;

  always_comb begin
    if (serial_mode_i)     off_d = serial_hit_w;
    else if (level_rise_w) off_d = low_prio_mask_i;
    else                   off_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_q <= '0;
    else        off_q <= off_d;
  end
  assign port_off_o = off_q;

  // R10: every request is a single-cycle pulse
  assert_pulse_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (port_off_o != '0) |=> (port_off_o == '0));

  // R2: level-mode requests stay within the low-priority mask
  assert_level_in_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(serial_mode_i) && port_off_o != '0) |-> ((port_off_o & ~$past(low_prio_mask_i)) == '0));

endmodule

// File: tb/tb_shutdown_prio_decoder.sv
module tb_shutdown_prio_decoder;
  localparam int NP   = 8;
  localparam int DEG  = 4;
  localparam int BIT  = 40;
  localparam int GAP  = 60;
  localparam int ARM  = 100;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            raw = 1'b0;
  logic            mode = 1'b0;
  logic [NP-1:0]   mask = '0;
  logic [NP*3-1:0] prio = '0;
  logic [NP-1:0]   off;

  int checks = 0;
  int fails  = 0;
  string cur_tag = "R10";
  logic [NP-1:0] exp_q[$];
  string         tag_q[$];

  always #5 clk = ~clk;

  shutdown_prio_decoder #(
    .NUM_PORTS(NP), .SYNC_STAGES(2), .DEGLITCH_CYC(DEG),
    .BIT_CYC(BIT), .GAP_CYC(GAP), .ARM_CYC(ARM)
  ) dut (
    .clk(clk), .rst_n(rst_n), .shdn_raw_i(raw), .serial_mode_i(mode),
    .low_prio_mask_i(mask), .prio_flat_i(prio), .port_off_o(off)
  );

  // Monitor: every nonzero pulse must match the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && off != '0) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL %s: unexpected pulse actual=%h expected=00", cur_tag, off);
      end else begin
        automatic logic [NP-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (off !== e) begin
          fails++;
          $display("FAIL %s: pulse actual=%h expected=%h", t, off, e);
        end
      end
    end
  end

  function automatic logic [NP-1:0] model(logic [2:0] code, logic [NP*3-1:0] p);
    logic [NP-1:0] v;
    for (int i = 0; i < NP; i++) v[i] = (p[i*3 +: 3] >= code);
    return v;
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic push(logic [NP-1:0] v, string t);
    if (v != '0) begin
      exp_q.push_back(v);
      tag_q.push_back(t);
    end
  endtask

  task automatic send_frame(logic [2:0] code);
    raw = 1'b1; tick(BIT);
    for (int b = 2; b >= 0; b--) begin
      raw = code[b]; tick(BIT);
    end
    raw = 1'b0;
  endtask

  task automatic settle(string t, int n);
    tick(n);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL %s: missing pulse actual=none expected=%h", t, exp_q[0]);
      exp_q.delete(); tag_q.delete();
    end
  endtask

  initial begin
    int wd = 0;
    while (wd < 100000) begin
      @(posedge clk);
      wd++;
    end
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick(3);
    checks++;
    if (off !== '0) begin
      fails++;
      $display("FAIL R10: reset output actual=%h expected=00", off);
    end
    rst_n = 1'b1;
    tick(5);

    // R2 / R3: level mode
    cur_tag = "R2"; mask = 8'hA5;
    push(8'hA5, "R2"); raw = 1'b1;
    cur_tag = "R3"; tick(80);
    raw = 1'b0; settle("R2", 20);
    cur_tag = "R2"; mask = 8'h3C;
    push(8'h3C, "R2"); raw = 1'b1; tick(10); raw = 1'b0;
    settle("R2", 20);

    // R1: glitch shorter than the filter, then one just long enough
    cur_tag = "R1"; raw = 1'b1; tick(2); raw = 1'b0;
    settle("R1", 20);
    push(8'h3C, "R1"); raw = 1'b1; tick(DEG + 1); raw = 1'b0;
    settle("R1", 20);

    // R7: frames before the arming quiet period are ignored
    prio = '0;
    for (int i = 0; i < NP; i++) prio[i*3 +: 3] = 3'(i);
    mode = 1'b1; tick(20);
    cur_tag = "R7"; send_frame(3'd0);
    settle("R7", ARM + 40);

    // R4 / R5: codes against ascending priorities
    cur_tag = "R5"; push(model(3'd3, prio), "R5"); send_frame(3'd3); settle("R5", GAP + 20);
    push(model(3'd0, prio), "R4"); send_frame(3'd0); settle("R4", GAP + 20);
    push(model(3'd7, prio), "R5"); send_frame(3'd7); settle("R5", GAP + 20);
    push(model(3'd6, prio), "R4"); send_frame(3'd6); settle("R4", GAP + 20);
    prio = {3'd4, 3'd1, 3'd6, 3'd2, 3'd2, 3'd5, 3'd0, 3'd7};
    push(model(3'd2, prio), "R5"); send_frame(3'd2); settle("R5", GAP + 20);
    push(model(3'd5, prio), "R4"); send_frame(3'd5); settle("R4", GAP + 20);

    // R6: code above every priority
    for (int i = 0; i < NP; i++) prio[i*3 +: 3] = 3'd2;
    cur_tag = "R6"; send_frame(3'd5); settle("R6", GAP + 20);

    // R9: start bit too short to survive to its middle
    cur_tag = "R9"; raw = 1'b1; tick(10); raw = 1'b0;
    settle("R9", GAP + 40);
    push(model(3'd1, prio), "R9"); send_frame(3'd1); settle("R9", GAP + 20);

    // R8: second frame without a gap is ignored
    prio = {3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0};
    cur_tag = "R8"; push(model(3'd2, prio), "R8"); send_frame(3'd2);
    tick(10); send_frame(3'd5);
    settle("R8", GAP + 40);

    // R2: back to level mode
    mode = 1'b0; mask = 8'h81; cur_tag = "R2";
    push(8'h81, "R2"); raw = 1'b1; tick(20); raw = 1'b0;
    settle("R2", 20);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule